// File: doc/BRIEF.md
# Omega Network Destination-Tag Router

This block steers up to N packets at once through a multistage Omega network of 2×2 switches, where N is a power of two and the network has log2 N stages. Each input line offers a valid flag, a destination tag and a payload. Ahead of every stage the lines pass through a perfect shuffle, which rotates the line index left by one bit. The switches in stage i then set themselves from one bit of each packet's destination tag. No central controller is involved.

Some permutations need one switch in two settings at once, so they cannot be routed in a single pass. When two packets at a switch ask for the same output, the packet on the upper input keeps the path and the other is dropped for that pass. The dropped packet's source input is flagged as blocked so that the sender can offer it again in a later pass. Delivered and blocked flags are reported per input, so a scheduler can resubmit exactly the packets that lost.

The block works one pass at a time. A pulse on `start` samples all inputs. One cycle later the routed outputs and the per-input status flags appear in registers, and they hold until the next pass.

Top module: `omega_router`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `done`, `out_valid`, `delivered` and `blocked` are all zero.
- R2: `done` is high in exactly the cycle after a cycle with `start` high. When `start` is low, every result output keeps its value in the next cycle, whatever the other inputs do.
- R3: Stage i (stage 0 at the input side) steers on destination bit TAG_W-1-i: 0 selects the switch's upper output and 1 selects the lower output. A packet that is not blocked appears at output index equal to its destination tag, with its payload on `out_data` and its source input number on `out_src`.
- R4: At stage 0, input j and input j+N/2 (for j < N/2) share one switch, and input j arrives on the upper port. If both are valid and have the same most significant destination bit, input j is delivered and input j+N/2 is blocked. Input 0 is therefore never blocked.
- R5: After a pass, each valid input is flagged either `delivered` or `blocked`, never both. An invalid input is flagged neither.
- R6: Invalid inputs never block a valid input and never raise any `out_valid` bit. With no valid input, all `out_valid` bits are zero after the pass.
- R7: The number of set `out_valid` bits equals the number of set `delivered` bits.
- R8: Conflicts are resolved stage by stage, and at every stage the upper switch input wins. A packet dropped at an earlier stage takes up no switch later on. For N = 8, stage 1 pairs inputs 0 and 2 when both have destination bit 2 clear, and stage 2 pairs inputs 0 and 1 when both have the same destination. In each case the lower-numbered input wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample all inputs and route one pass |
| in_valid | input | N_PORTS | Per-input packet present |
| in_dest | input | N_PORTS*TAG_W | Destination tags, input j in bits [j*TAG_W +: TAG_W] |
| in_data | input | N_PORTS*DATA_W | Payloads, input j in bits [j*DATA_W +: DATA_W] |
| done | output | 1 | Results of the pass sampled in the previous cycle are present |
| out_valid | output | N_PORTS | Per-output packet delivered |
| out_data | output | N_PORTS*DATA_W | Delivered payload per output |
| out_src | output | N_PORTS*TAG_W | Source input number per output |
| delivered | output | N_PORTS | Per-input: packet reached its destination |
| blocked | output | N_PORTS | Per-input: packet lost a switch conflict |

## Verification
The bench builds the router with eight ports, so there are three stages and three tag bits, and with 8-bit payloads. At this size a conflict can be placed at each stage on purpose. The pattern that sends every input to one output makes losers at all three stages at once, which exercises the rule that a dropped packet no longer competes. The same size also allows whole permutations that must pass without conflict (identity, XOR with a constant, cyclic shift), and every output index of these can be checked against its source.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Perfect shuffle: rotate a line index of BITS bits left by one.
  function automatic int rotl_idx(int idx, int bits);
    int msb;
    msb = (idx >> (bits - 1)) & 1;
    return ((idx << 1) & ((1 << bits) - 1)) | msb;
  endfunction

  // Inverse shuffle: which upstream line feeds shuffled position idx.
  function automatic int rotr_idx(int idx, int bits);
    int lsb;
    lsb = idx & 1;
    return (idx >> 1) | (lsb << (bits - 1));
  endfunction

endpackage

// File: rtl/omega_switch2.sv
module omega_switch2 #(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 8,
  parameter int STAGE  = 0
) (
  input  logic              a_vld,
  input  logic [TAG_W-1:0]  a_dst,
  input  logic [DATA_W-1:0] a_dat,
  input  logic [TAG_W-1:0]  a_src,
  input  logic              b_vld,
  input  logic [TAG_W-1:0]  b_dst,
  input  logic [DATA_W-1:0] b_dat,
  input  logic [TAG_W-1:0]  b_src,
  output logic              up_vld,
  output logic [TAG_W-1:0]  up_dst,
  output logic [DATA_W-1:0] up_dat,
  output logic [TAG_W-1:0]  up_src,
  output logic              lo_vld,
  output logic [TAG_W-1:0]  lo_dst,
  output logic [DATA_W-1:0] lo_dat,
  output logic [TAG_W-1:0]  lo_src,
  output logic              kill_vld,
  output logic [TAG_W-1:0]  kill_src
);
  localparam int STEER_BIT = TAG_W - 1 - STAGE;

  logic a_bit, b_bit, clash, b_go, a_up, a_lo;

  always_comb begin
    a_bit  = a_dst[STEER_BIT];
    b_bit  = b_dst[STEER_BIT];
    clash  = a_vld && b_vld && (a_bit == b_bit);
    b_go   = b_vld && !clash;
    a_up   = a_vld && !a_bit;
    a_lo   = a_vld && a_bit;

    up_vld = a_up || (b_go && !b_bit);
    lo_vld = a_lo || (b_go && b_bit);

    up_dst = a_up ? a_dst : b_dst;
    up_dat = a_up ? a_dat : b_dat;
    up_src = a_up ? a_src : b_src;
    lo_dst = a_lo ? a_dst : b_dst;
    lo_dat = a_lo ? a_dat : b_dat;
    lo_src = a_lo ? a_src : b_src;

    kill_vld = clash;
    kill_src = b_src;
  end
endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int N_PORTS = 8,
  parameter int TAG_W   = 3,
  parameter int DATA_W  = 8,
  parameter int STAGE   = 0
) (
  input  logic [N_PORTS-1:0]                i_vld,
  input  logic [N_PORTS-1:0][TAG_W-1:0]     i_dst,
  input  logic [N_PORTS-1:0][DATA_W-1:0]    i_dat,
  input  logic [N_PORTS-1:0][TAG_W-1:0]     i_src,
  output logic [N_PORTS-1:0]                o_vld,
  output logic [N_PORTS-1:0][TAG_W-1:0]     o_dst,
  output logic [N_PORTS-1:0][DATA_W-1:0]    o_dat,
  output logic [N_PORTS-1:0][TAG_W-1:0]     o_src,
  output logic [N_PORTS/2-1:0]              kill_vld,
  output logic [N_PORTS/2-1:0][TAG_W-1:0]   kill_src
);
  localparam int N_SW = N_PORTS / 2;

  logic [N_PORTS-1:0]             s_vld;
  logic [N_PORTS-1:0][TAG_W-1:0]  s_dst;
  logic [N_PORTS-1:0][DATA_W-1:0] s_dat;
  logic [N_PORTS-1:0][TAG_W-1:0]  s_src;

  // Perfect-shuffle wiring ahead of the switch column.
  for (genvar p = 0; p < N_PORTS; p++) begin : g_shuf
    localparam int FROM = omega_pkg::rotr_idx(p, TAG_W);
    assign s_vld[p] = i_vld[FROM];
    assign s_dst[p] = i_dst[FROM];
    assign s_dat[p] = i_dat[FROM];
    assign s_src[p] = i_src[FROM];
  end

  for (genvar k = 0; k < N_SW; k++) begin : g_sw
    omega_switch2 #(
      .TAG_W (TAG_W),
      .DATA_W(DATA_W),
      .STAGE (STAGE)
    ) u_sw (
      .a_vld   (s_vld[2*k]),
      .a_dst   (s_dst[2*k]),
      .a_dat   (s_dat[2*k]),
      .a_src   (s_src[2*k]),
      .b_vld   (s_vld[2*k+1]),
      .b_dst   (s_dst[2*k+1]),
      .b_dat   (s_dat[2*k+1]),
      .b_src   (s_src[2*k+1]),
      .up_vld  (o_vld[2*k]),
      .up_dst  (o_dst[2*k]),
      .up_dat  (o_dat[2*k]),
      .up_src  (o_src[2*k]),
      .lo_vld  (o_vld[2*k+1]),
      .lo_dst  (o_dst[2*k+1]),
      .lo_dat  (o_dat[2*k+1]),
      .lo_src  (o_src[2*k+1]),
      .kill_vld(kill_vld[k]),
      .kill_src(kill_src[k])
    );
  end
endmodule

// File: rtl/omega_router.sv
module omega_router #(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 8,
  parameter int TAG_W   = $clog2(N_PORTS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [N_PORTS-1:0]          in_valid,
  input  logic [N_PORTS*TAG_W-1:0]    in_dest,
  input  logic [N_PORTS*DATA_W-1:0]   in_data,
  output logic                        done,
  output logic [N_PORTS-1:0]          out_valid,
  output logic [N_PORTS*DATA_W-1:0]   out_data,
  output logic [N_PORTS*TAG_W-1:0]    out_src,
  output logic [N_PORTS-1:0]          delivered,
  output logic [N_PORTS-1:0]          blocked
);
  localparam int N_STAGES = TAG_W;
  localparam int N_SW     = N_PORTS / 2;

  logic [N_STAGES:0][N_PORTS-1:0]              ln_vld;
  logic [N_STAGES:0][N_PORTS-1:0][TAG_W-1:0]   ln_dst;
  logic [N_STAGES:0][N_PORTS-1:0][DATA_W-1:0]  ln_dat;
  logic [N_STAGES:0][N_PORTS-1:0][TAG_W-1:0]   ln_src;

  logic [N_STAGES-1:0][N_SW-1:0]               kv;
  logic [N_STAGES-1:0][N_SW-1:0][TAG_W-1:0]    ks;
  logic [N_PORTS-1:0]                          lost;

  for (genvar j = 0; j < N_PORTS; j++) begin : g_in
    assign ln_vld[0][j] = in_valid[j];
    assign ln_dst[0][j] = in_dest[j*TAG_W +: TAG_W];
    assign ln_dat[0][j] = in_data[j*DATA_W +: DATA_W];
    assign ln_src[0][j] = TAG_W'(j);
  end

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    omega_stage #(
      .N_PORTS(N_PORTS),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W),
      .STAGE  (s)
    ) u_stage (
      .i_vld   (ln_vld[s]),
      .i_dst   (ln_dst[s]),
      .i_dat   (ln_dat[s]),
      .i_src   (ln_src[s]),
      .o_vld   (ln_vld[s+1]),
      .o_dst   (ln_dst[s+1]),
      .o_dat   (ln_dat[s+1]),
      .o_src   (ln_src[s+1]),
      .kill_vld(kv[s]),
      .kill_src(ks[s])
    );
  end

  // Map every switch loser back to its source input.
  always_comb begin
    lost = '0;
    for (int s = 0; s < N_STAGES; s++) begin
      for (int k = 0; k < N_SW; k++) begin
        if (kv[s][k]) lost[ks[s][k]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      out_valid <= '0;
      out_data  <= '0;
      out_src   <= '0;
      delivered <= '0;
      blocked   <= '0;
    end else begin
      done <= start;
      if (start) begin
        out_valid <= ln_vld[N_STAGES];
        out_data  <= ln_dat[N_STAGES];
        out_src   <= ln_src[N_STAGES];
        delivered <= in_valid & ~lost;
        blocked   <= lost;
      end
    end
  end
endmodule

// File: rtl/omega_router_chk.sv
module omega_router_chk #(
  parameter int N_PORTS = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [N_PORTS-1:0] in_valid,
  input logic               done,
  input logic [N_PORTS-1:0] out_valid,
  input logic [N_PORTS-1:0] delivered,
  input logic [N_PORTS-1:0] blocked
);
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |=> done); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done); // R2
  AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(out_valid) && $stable(delivered) && $stable(blocked))); // R2
  AST_STATUS_COVERS_VALID: assert property (@(posedge clk) disable iff (rst)
    start |=> ((delivered | blocked) == $past(in_valid))); // R5
  AST_OUT_COUNT: assert property (@(posedge clk) disable iff (rst)
    $countones(out_valid) == $countones(delivered)); // R7
  AST_INPUT0_WINS: assert property (@(posedge clk) disable iff (rst)
    done |-> !blocked[0]); // R4
  AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    (start && in_valid == '0) |=> (out_valid == '0)); // R6
endmodule

bind omega_router omega_router_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .in_valid (in_valid),
  .done     (done),
  .out_valid(out_valid),
  .delivered(delivered),
  .blocked  (blocked)
);

// File: tb/sim_omega_router.sv
module sim_omega_router;
  localparam int N  = 8;
  localparam int TW = 3;
  localparam int DW = 8;
  localparam int NROWS = 9;

  // Destination nibble per input (input j in bits [4j+:3]), valid mask, expected blocked mask.
  localparam logic [31:0] ROW_DST [NROWS] = '{
    32'h76543210, 32'h23016745, 32'h00000000, 32'h00020003, 32'h00020003,
    32'h00000100, 32'h00000066, 32'h07654321, 32'h76543210 };
  localparam logic [7:0] ROW_VLD [NROWS] = '{
    8'hFF, 8'hFF, 8'hFF, 8'h11, 8'h10, 8'h05, 8'h03, 8'hFF, 8'h00 };
  localparam logic [7:0] ROW_BLK [NROWS] = '{
    8'h00, 8'h00, 8'hFE, 8'h10, 8'h00, 8'h04, 8'h02, 8'h00, 8'h00 };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [N-1:0]    in_valid = '0;
  logic [N*TW-1:0] in_dest  = '0;
  logic [N*DW-1:0] in_data  = '0;
  logic            done;
  logic [N-1:0]    out_valid;
  logic [N*DW-1:0] out_data;
  logic [N*TW-1:0] out_src;
  logic [N-1:0]    delivered;
  logic [N-1:0]    blocked;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  omega_router #(.N_PORTS(N), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .done(done), .out_valid(out_valid), .out_data(out_data),
    .out_src(out_src), .delivered(delivered), .blocked(blocked));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load_row(input int r);
    for (int j = 0; j < N; j++) begin
      in_dest[j*TW +: TW] = ROW_DST[r][j*4 +: 3];
      in_data[j*DW +: DW] = DW'(r*16 + j + 8'h40);
    end
    in_valid = ROW_VLD[r];
  endtask

  task automatic run_pass;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [N-1:0] exp_ov;
    logic [N-1:0] keep_ov, keep_dl, keep_bl;
    int d;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done == 1'b0 && out_valid == '0, "R1", "done/out_valid in reset", {done, out_valid}, 0);
    chk(delivered == '0 && blocked == '0, "R1", "status in reset", {delivered, blocked}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && out_valid == '0 && delivered == '0 && blocked == '0,
        "R1", "state after reset", {done, out_valid, delivered, blocked}, 0);

    for (int r = 0; r < NROWS; r++) begin
      load_row(r);
      run_pass();
      chk(done == 1'b1, "R2", $sformatf("row %0d done", r), done, 1);
      chk(blocked == ROW_BLK[r], "R4 R8", $sformatf("row %0d blocked", r), blocked, ROW_BLK[r]);
      chk(delivered == (ROW_VLD[r] & ~ROW_BLK[r]), "R5", $sformatf("row %0d delivered", r),
          delivered, ROW_VLD[r] & ~ROW_BLK[r]);
      exp_ov = '0;
      for (int j = 0; j < N; j++) begin
        if (ROW_VLD[r][j] && !ROW_BLK[r][j]) begin
          d = int'(ROW_DST[r][j*4 +: 3]);
          exp_ov[d] = 1'b1;
          chk(out_data[d*DW +: DW] == DW'(r*16 + j + 8'h40), "R3",
              $sformatf("row %0d out %0d data", r, d), out_data[d*DW +: DW], r*16 + j + 8'h40);
          chk(out_src[d*TW +: TW] == TW'(j), "R3",
              $sformatf("row %0d out %0d src", r, d), out_src[d*TW +: TW], j);
        end
      end
      chk(out_valid == exp_ov, "R6 R7", $sformatf("row %0d out_valid", r), out_valid, exp_ov);
      @(negedge clk);
      chk(done == 1'b0, "R2", $sformatf("row %0d done drops", r), done, 0);
    end

    // R2: inputs changing without start leave results untouched.
    load_row(2);
    run_pass();
    keep_ov = out_valid; keep_dl = delivered; keep_bl = blocked;
    load_row(0);
    repeat (4) @(negedge clk);
    chk(out_valid == keep_ov && delivered == keep_dl && blocked == keep_bl, "R2",
        "hold without start", {out_valid, delivered, blocked}, {keep_ov, keep_dl, keep_bl});
    chk(done == 1'b0, "R2", "no done without start", done, 0);

    // R6: an invalid upper packet with a clashing tag does not block the lower one.
    load_row(4);
    in_dest[0 +: TW] = 3'd2;
    run_pass();
    chk(blocked == '0 && delivered == 8'h10, "R6", "invalid upper does not block",
        {blocked, delivered}, 8'h10);
    chk(out_valid == 8'h04, "R6", "only lower packet reaches output 2", out_valid, 8'h04);

    // R1: reset after a pass clears the results.
    load_row(0);
    run_pass();
    rst = 1'b1;
    @(negedge clk);
    chk(out_valid == '0 && delivered == '0 && blocked == '0 && done == 1'b0, "R1",
        "reset clears results", {out_valid, delivered, blocked}, 0);
    rst = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule